// File: doc/BRIEF.md
# Tint-Mapped Column Translation Buffer

This block is a small fully associative address translation buffer for a processor whose data cache can be split into groups of ways. Each page entry holds the physical page, a cacheable flag and a small tint number. A separate table, written by software, turns each tint into a column mask with one bit per cache way. On every lookup the block returns the translation together with the resolved mask. The mask travels on its own output straight to the cache's victim selection logic, which may only replace lines in the ways the mask allows.

Because pages point at a tint rather than holding a raw way mask, a whole group of pages can be moved to other ways by rewriting a single tint register. Lookup and tint resolution are purely combinational, so results appear in the same cycle as the request. A miss raises a flag and nothing more. Page walking and permission checks belong to other logic, which installs entries through an explicit write port. Slots for new pages are chosen in round-robin order.

Top module: `tint_tlb`

## Requirements
- R1: A lookup (`lk_valid`=1) whose page number matches a valid entry drives `lk_hit`=1, `lk_miss`=0, and the entry's physical page, cacheable bit and tint mask on `lk_ppn`, `lk_cacheable` and `lk_ways` in the same cycle.
- R2: A lookup that matches no valid entry drives `lk_miss`=1, `lk_hit`=0, and zero on `lk_ppn`, `lk_cacheable` and `lk_ways`.
- R3: With `lk_valid`=0, `lk_hit`, `lk_miss`, `lk_ppn`, `lk_cacheable` and `lk_ways` are all zero.
- R4: Reset invalidates every entry and sets every tint mask to all ones, so a page installed with a tint that has never been written resolves to all ways allowed.
- R5: An install through `ent_we` takes effect at the next rising clock edge. A lookup of the same page in the install cycle still sees the old contents.
- R6: Installing a page that is not present writes the slot named by a round-robin pointer. The pointer starts at slot 0 after reset, advances by one per such install, and wraps after the last slot. With 8 slots, the ninth new page evicts the first.
- R7: Installing a page that is already present overwrites that entry in place and leaves the round-robin pointer unchanged.
- R8: A tint table write (`tint_we`, `tint_idx`, `tint_mask`) changes the mask returned for every page that carries that tint from the next cycle on. Pages with other tints keep their masks.
- R9: When a tint table write and a hit on a page with that same tint happen in one cycle, `lk_ways` returns the mask being written. A hit on a page with a different tint returns its stored mask.
- R10: The cacheable bit is kept per entry, independently of the tint. Two pages with the same tint may differ in `lk_cacheable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number looked up |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup matched no entry |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_cacheable | output | 1 | Cacheable attribute of the hit |
| lk_ways | output | WAYS | Column mask sent to the cache victim selection |
| ent_we | input | 1 | Install an entry |
| ent_vpn | input | VPN_W | Virtual page of the new entry |
| ent_ppn | input | PPN_W | Physical page of the new entry |
| ent_tint | input | TINT_W | Tint of the new entry |
| ent_cacheable | input | 1 | Cacheable attribute of the new entry |
| tint_we | input | 1 | Write one tint table register |
| tint_idx | input | TINT_W | Tint register selected |
| tint_mask | input | WAYS | New column mask |

## Verification
All lookup results are combinational. The bench therefore drives a request just after a falling edge and samples the outputs one time unit later, while the request is still in the same cycle. Installs and tint writes commit at the following rising edge, so any check that they took effect is made in a later cycle. The two same-cycle cases are the exceptions. The install-cycle miss and the tint bypass are both sampled while the write is still pending, before that edge.

// File: rtl/tint_tlb.sv
module tint_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int TINT_W  = 2,
  parameter int WAYS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_cacheable,
  output logic [WAYS-1:0]   lk_ways,
  input  logic              ent_we,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [PPN_W-1:0]  ent_ppn,
  input  logic [TINT_W-1:0] ent_tint,
  input  logic              ent_cacheable,
  input  logic              tint_we,
  input  logic [TINT_W-1:0] tint_idx,
  input  logic [WAYS-1:0]   tint_mask
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TINTS = 1 << TINT_W;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [TINT_W-1:0]  tint_q [ENTRIES];
  logic [ENTRIES-1:0] cach_q;
  logic [WAYS-1:0]    mask_q [TINTS];
  logic [IDX_W-1:0]   ptr_q;

  logic             hit_any, ent_found;
  logic [IDX_W-1:0] hit_idx, ent_idx, wr_slot;
  logic [TINT_W-1:0] hit_tint;
  logic [WAYS-1:0]  resolved;

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    ent_found = 1'b0;
    ent_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && vpn_q[i] == lk_vpn) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (vld_q[i] && vpn_q[i] == ent_vpn) begin
        ent_found = 1'b1;
        ent_idx = IDX_W'(i);
      end
    end
  end

  assign hit_tint = tint_q[hit_idx];
  assign resolved = (tint_we && tint_idx == hit_tint) ? tint_mask : mask_q[hit_tint];
  assign wr_slot  = ent_found ? ent_idx : ptr_q;

  assign lk_hit       = lk_valid & hit_any;
  assign lk_miss      = lk_valid & ~hit_any;
  assign lk_ppn       = lk_hit ? ppn_q[hit_idx] : '0;
  assign lk_cacheable = lk_hit & cach_q[hit_idx];
  assign lk_ways      = lk_hit ? resolved : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int t = 0; t < TINTS; t++) mask_q[t] <= '1;
    end else begin
      if (ent_we) begin
        vld_q[wr_slot] <= 1'b1;
        if (!ent_found)
          ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
      if (tint_we) mask_q[tint_idx] <= tint_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_we) begin
      vpn_q[wr_slot]  <= ent_vpn;
      ppn_q[wr_slot]  <= ent_ppn;
      tint_q[wr_slot] <= ent_tint;
      cach_q[wr_slot] <= ent_cacheable;
    end
  end

  assert_hit_miss_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss}));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss && lk_ways == '0));

  assert_miss_no_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_ways == '0 && lk_ppn == '0 && !lk_cacheable));

  assert_install_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |=> (!(lk_valid && lk_vpn == $past(ent_vpn)) ||
                (lk_hit && lk_ppn == $past(ent_ppn))));

  assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && !ent_found && ptr_q != IDX_W'(ENTRIES - 1)) |=> ptr_q == $past(ptr_q) + 1'b1);

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && ent_found) |=> $stable(ptr_q));

  assert_tint_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tint_we && !ent_we) |=> ((lk_hit && hit_tint == $past(tint_idx) &&
                               !(tint_we && tint_idx == hit_tint))
                              -> lk_ways == $past(tint_mask)));

  assert_tint_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && tint_we && tint_idx == hit_tint) |-> lk_ways == tint_mask);

endmodule

// File: tb/tint_tlb_tb.sv
module tint_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20, PPN_W = 16, TINT_W = 2, WAYS = 4;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic lk_hit, lk_miss, lk_cacheable;
  logic [PPN_W-1:0] lk_ppn;
  logic [WAYS-1:0] lk_ways;
  logic ent_we = 0, ent_cacheable = 0;
  logic [VPN_W-1:0] ent_vpn = '0;
  logic [PPN_W-1:0] ent_ppn = '0;
  logic [TINT_W-1:0] ent_tint = '0;
  logic tint_we = 0;
  logic [TINT_W-1:0] tint_idx = '0;
  logic [WAYS-1:0] tint_mask = '0;

  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tint_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn),
    .lk_cacheable(lk_cacheable), .lk_ways(lk_ways),
    .ent_we(ent_we), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn),
    .ent_tint(ent_tint), .ent_cacheable(ent_cacheable),
    .tint_we(tint_we), .tint_idx(tint_idx), .tint_mask(tint_mask)
  );

  // vector: vpn(20) hit(1) ppn(16) cacheable(1) mask(4)
  localparam logic [41:0] VECS [5] = '{
    {20'h00010, 1'b1, 16'h0100, 1'b1, 4'b1111},
    {20'h00011, 1'b1, 16'h0111, 1'b0, 4'b0011},
    {20'h00012, 1'b1, 16'h0122, 1'b1, 4'b1100},
    {20'h00013, 1'b1, 16'h0133, 1'b1, 4'b0011},
    {20'h00014, 1'b0, 16'h0000, 1'b0, 4'b0000}
  };

  task automatic check(input string tag, input logic [PPN_W+WAYS+2:0] act,
                       input logic [PPN_W+WAYS+2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag, input logic [VPN_W-1:0] vpn, input logic hit,
                      input logic [PPN_W-1:0] ppn, input logic c, input logic [WAYS-1:0] m);
    @(negedge clk);
    lk_valid = 1; lk_vpn = vpn;
    #1;
    check(tag, {lk_hit, lk_miss, lk_ppn, lk_cacheable, lk_ways}, {hit, ~hit, ppn, c, m});
  endtask

  task automatic install(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                         input logic [TINT_W-1:0] t, input logic c);
    @(negedge clk);
    ent_we = 1; ent_vpn = vpn; ent_ppn = ppn; ent_tint = t; ent_cacheable = c;
    @(negedge clk);
    ent_we = 0;
  endtask

  task automatic set_tint(input logic [TINT_W-1:0] t, input logic [WAYS-1:0] m);
    @(negedge clk);
    tint_we = 1; tint_idx = t; tint_mask = m;
    @(negedge clk);
    tint_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    #1;
    check("R3 idle after reset", {lk_hit, lk_miss, lk_ppn, lk_cacheable, lk_ways}, '0);
    look("R2 R4 empty after reset", 20'h00010, 0, 0, 0, 0);

    // R5: install in flight, lookup same cycle still misses
    @(negedge clk);
    ent_we = 1; ent_vpn = 20'h00010; ent_ppn = 16'h0100; ent_tint = 0; ent_cacheable = 1;
    lk_valid = 1; lk_vpn = 20'h00010;
    #1;
    check("R5 install not yet visible", {lk_hit, lk_miss, lk_ppn, lk_cacheable, lk_ways},
          {1'b0, 1'b1, 16'h0, 1'b0, 4'h0});
    @(negedge clk); ent_we = 0;
    #1;
    check("R5 install visible next cycle", {lk_hit, lk_miss, lk_ppn, lk_cacheable, lk_ways},
          {1'b1, 1'b0, 16'h0100, 1'b1, 4'b1111});

    install(20'h00011, 16'h0111, 1, 0);
    install(20'h00012, 16'h0122, 2, 1);
    install(20'h00013, 16'h0133, 1, 1);
    set_tint(1, 4'b0011);
    set_tint(2, 4'b1100);

    for (int k = 0; k < 5; k++)
      look("R1 R2 R4 R10 vector", VECS[k][41:22], VECS[k][21], VECS[k][20:5],
           VECS[k][4], VECS[k][3:0]);

    @(negedge clk); lk_valid = 0;
    #1;
    check("R3 idle with entries", {lk_hit, lk_miss, lk_ppn, lk_cacheable, lk_ways}, '0);

    // R8: one write repartitions every page of tint 1
    set_tint(1, 4'b0101);
    look("R8 page A tint1", 20'h00011, 1, 16'h0111, 0, 4'b0101);
    look("R8 page B tint1", 20'h00013, 1, 16'h0133, 1, 4'b0101);
    look("R8 other tint kept", 20'h00012, 1, 16'h0122, 1, 4'b1100);

    // R9: same-cycle bypass
    @(negedge clk);
    tint_we = 1; tint_idx = 1; tint_mask = 4'b1000;
    lk_valid = 1; lk_vpn = 20'h00013;
    #1;
    check("R9 bypass matching tint", {lk_hit, lk_ways}, {1'b1, 4'b1000});
    lk_vpn = 20'h00012;
    #1;
    check("R9 no bypass other tint", {lk_hit, lk_ways}, {1'b1, 4'b1100});
    @(negedge clk); tint_we = 0;

    // R6/R7: fill slots 4..7, reinstall present page, then one new page
    install(20'h00014, 16'h0144, 0, 0);
    install(20'h00015, 16'h0155, 0, 0);
    install(20'h00016, 16'h0166, 0, 0);
    install(20'h00017, 16'h0177, 0, 0);
    install(20'h00011, 16'h01AA, 3, 1);
    look("R7 overwrite in place", 20'h00011, 1, 16'h01AA, 1, 4'b1111);
    install(20'h00018, 16'h0188, 2, 0);
    look("R6 oldest slot evicted", 20'h00010, 0, 0, 0, 0);
    look("R6 R7 pointer not advanced", 20'h00011, 1, 16'h01AA, 1, 4'b1111);
    look("R6 new page present", 20'h00018, 1, 16'h0188, 0, 4'b1100);
    look("R6 other entries kept", 20'h00017, 1, 16'h0177, 0, 4'b1111);

    // R4: reset restores all-ones masks and empties entries
    @(negedge clk); rst_n = 0; lk_valid = 0;
    @(negedge clk); rst_n = 1;
    look("R4 entries cleared", 20'h00012, 0, 0, 0, 0);
    install(20'h00020, 16'h0200, 1, 1);
    look("R4 tint mask all ones", 20'h00020, 1, 16'h0200, 1, 4'b1111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule